// File: doc/BRIEF.md
# Shadow Memory Attribute Router

This block decides, for every memory cycle that lands in the legacy shadow window below one megabyte, where that cycle goes. The window is cut into 16 KB regions. Each programmable 8-bit attribute byte governs a pair of neighbouring regions. The low nibble belongs to the even region of the pair and the high nibble to the odd one. In each nibble, bit 0 enables reads, bit 1 enables writes, bit 2 enables caching, and bit 3 has no effect.

For a processor cycle, the block reports whether local DRAM services it or whether it is passed to PCI for termination. It also reports whether the line may be held in the first-level and second-level caches. For a cycle from a PCI bus master, it instead decides whether to claim the cycle (request DEVSEL). A configurable memory hole vetoes all bus-master claims.

Because direction, initiator and fetch type all enter the decision, one address can be read from the expansion bus and written into DRAM. This is what lets firmware copy a ROM onto itself for shadowing. Addresses outside the window are treated as plain cacheable DRAM. All routing outputs are registered and appear one clock after the request.

Top module: `shadow_attr_router`

## Requirements
- R1: After reset every attribute byte reads 0x00, so every region in the window starts disabled and processor cycles to it go to PCI.
- R2: A configuration write stores the full byte at `cfg_idx`, and it can be read back on `cfg_rdata`. The region at window offset index r uses byte r/2, low nibble when r is even and high nibble when r is odd. Bits 3 and 7 never change routing.
- R3: With read and write enable both 0 (nibble bits [1:0] = 00), processor reads and writes to the region are forwarded to PCI and never go to DRAM.
- R4: With only read enable set (01), processor reads go to DRAM and processor writes are forwarded to PCI.
- R5: With only write enable set (10), processor reads are forwarded to PCI and processor writes go to DRAM. Neither cache flag is raised.
- R6: With both enables set (11), processor reads and writes go to DRAM.
- R7: In a read-only region, the L1 flag is raised only for a code fetch with cache enable (bit 2) set. The L2 flag is never raised.
- R8: In a read/write region, both cache flags equal cache enable. Cycles forwarded to PCI are never cacheable.
- R9: A bus-master write is claimed only if write enable is set, and a bus-master read only if read enable is set. A claimed cycle raises `rsp_dram`. Bus-master cycles never raise the forward or cache flags.
- R10: While `hole_en` is 1, a bus-master cycle with `hole_base <= addr < hole_limit` is never claimed. Processor cycles ignore the hole.
- R11: Outside the window, processor cycles go to DRAM with both cache flags set. Bus-master cycles there are claimed unless R10 applies.
- R12: Outputs reflect the request accepted at the previous clock edge. With no valid request at that edge, every output is 0.
- R13: For every valid processor cycle, exactly one of `rsp_dram` and `rsp_pci_fwd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute byte write strobe |
| cfg_idx | input | IDX_W | Attribute byte index for write and read |
| cfg_wdata | input | 8 | Attribute byte write data |
| cfg_rdata | output | 8 | Attribute byte at `cfg_idx` |
| req_valid | input | 1 | Memory cycle present |
| req_addr | input | ADDR_W | Cycle byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | Processor code fetch |
| req_pci | input | 1 | 1 = PCI bus master, 0 = processor |
| hole_en | input | 1 | Memory hole enable |
| hole_base | input | ADDR_W | First address of the hole |
| hole_limit | input | ADDR_W | First address past the hole |
| rsp_valid | output | 1 | Registered result valid |
| rsp_dram | output | 1 | DRAM services the cycle |
| rsp_pci_fwd | output | 1 | Cycle forwarded to PCI |
| rsp_l1_cache | output | 1 | L1 may cache the line |
| rsp_l2_cache | output | 1 | L2 may cache the line |
| rsp_claim | output | 1 | Bus-master cycle claimed |

## Verification
On every cycle, the assertions check the following:
- the one-clock latency and quiet idle outputs;
- the exclusive DRAM-or-PCI choice for processor cycles;
- that bus-master results never forward and match their claim;
- the hole veto;
- that L2 caching implies DRAM service;
- the reset clearing and landing of attribute writes.

What the assertions cannot see is whether each nibble pattern maps to the right destination and cache flags for each region, direction and fetch type. That is shown only by the bench sweep over all 256 attribute bytes, every region, and every access kind, together with the window-edge and hole scenarios.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

    typedef struct packed {
        logic cache_en;
        logic wr_en;
        logic rd_en;
    } attr_t;

    typedef struct packed {
        logic write;
        logic code;
        logic from_pci;
    } acc_t;

    typedef struct packed {
        logic valid;
        logic dram;
        logic fwd;
        logic l1;
        logic l2;
        logic claim;
    } route_t;

    function automatic attr_t to_attr(input logic [2:0] nib);
        attr_t a;
        a.cache_en = nib[2];
        a.wr_en    = nib[1];
        a.rd_en    = nib[0];
        return a;
    endfunction

endpackage

// File: rtl/shadow_attr_bank.sv
module shadow_attr_bank #(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (cfg_we && (cfg_idx == IDX_W'(i))) begin
                regs_d[i] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (cfg_idx == IDX_W'(i)) begin
                cfg_rdata = regs_q[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign regs_flat[g*8 +: 8] = regs_q[g];
        end
    endgenerate

    // R1: registers come out of reset cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> regs_flat == '0);

    // R2: a write lands in the addressed byte
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_idx) < NUM_REGS))
        |=> regs_flat[{$past(cfg_idx), 3'b000} +: 8] == $past(cfg_wdata));

endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode #(
    parameter int                ADDR_W       = 32,
    parameter int                NUM_REGS     = 4,
    parameter int                REGION_SHIFT = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE     = 'h000C_0000,
    parameter int                IDX_W        = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hole_en,
    input  logic [ADDR_W-1:0] hole_base,
    input  logic [ADDR_W-1:0] hole_limit,
    output logic              in_win,
    output logic [IDX_W-1:0]  reg_sel,
    output logic              upper,
    output logic              hole_hit
);

    localparam int              RIDX_W   = IDX_W + 1;
    localparam logic [ADDR_W:0] WIN_SIZE = (ADDR_W+1)'(NUM_REGS * 2) << REGION_SHIFT;

    logic [ADDR_W-1:0] offset;
    logic [RIDX_W-1:0] region;

    always_comb begin
        offset   = addr - WIN_BASE;
        in_win   = (addr >= WIN_BASE) && ({1'b0, offset} < WIN_SIZE);
        region   = offset[REGION_SHIFT +: RIDX_W];
        reg_sel  = region[RIDX_W-1:1];
        upper    = region[0];
        hole_hit = hole_en && (addr >= hole_base) && (addr < hole_limit);
    end

endmodule

// File: rtl/shadow_route_logic.sv
module shadow_route_logic
    import shadow_attr_pkg::*;
(
    input  attr_t  attr,
    input  acc_t   acc,
    input  logic   in_win,
    input  logic   hole_hit,
    output route_t route
);

    logic allowed;
    logic rw_region;
    logic ro_region;

    always_comb begin
        rw_region = attr.rd_en && attr.wr_en;
        ro_region = attr.rd_en && !attr.wr_en;
        allowed   = acc.write ? attr.wr_en : attr.rd_en;
        route     = '0;
        if (acc.from_pci) begin
            route.claim = (!in_win || allowed) && !hole_hit;
            route.dram  = route.claim;
        end else if (!in_win) begin
            route.dram = 1'b1;
            route.l1   = 1'b1;
            route.l2   = 1'b1;
        end else begin
            route.dram = allowed;
            route.fwd  = !allowed;
            route.l1   = allowed && attr.cache_en &&
                         (rw_region || (ro_region && acc.code));
            route.l2   = allowed && attr.cache_en && rw_region;
        end
    end

endmodule

// File: rtl/shadow_attr_router.sv
module shadow_attr_router
    import shadow_attr_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                NUM_REGS     = 4,
    parameter int                REGION_SHIFT = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE     = 'h000C_0000,
    localparam int               IDX_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_code,
    input  logic              req_pci,
    input  logic              hole_en,
    input  logic [ADDR_W-1:0] hole_base,
    input  logic [ADDR_W-1:0] hole_limit,
    output logic              rsp_valid,
    output logic              rsp_dram,
    output logic              rsp_pci_fwd,
    output logic              rsp_l1_cache,
    output logic              rsp_l2_cache,
    output logic              rsp_claim
);

    logic [NUM_REGS*8-1:0] regs_flat;
    logic                  in_win;
    logic [IDX_W-1:0]      reg_sel;
    logic                  upper;
    logic                  hole_hit;
    attr_t                 attr;
    acc_t                  acc;
    route_t                route;
    route_t                rsp_d;
    route_t                rsp_q;

    shadow_attr_bank #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .regs_flat (regs_flat)
    );

    shadow_region_decode #(
        .ADDR_W       (ADDR_W),
        .NUM_REGS     (NUM_REGS),
        .REGION_SHIFT (REGION_SHIFT),
        .WIN_BASE     (WIN_BASE),
        .IDX_W        (IDX_W)
    ) u_decode (
        .addr       (req_addr),
        .hole_en    (hole_en),
        .hole_base  (hole_base),
        .hole_limit (hole_limit),
        .in_win     (in_win),
        .reg_sel    (reg_sel),
        .upper      (upper),
        .hole_hit   (hole_hit)
    );

    always_comb begin
        attr         = to_attr(regs_flat[{reg_sel, upper, 2'b00} +: 3]);
        acc.write    = req_write;
        acc.code     = req_code;
        acc.from_pci = req_pci;
    end

    shadow_route_logic u_route (
        .attr     (attr),
        .acc      (acc),
        .in_win   (in_win),
        .hole_hit (hole_hit),
        .route    (route)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d       = route;
            rsp_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_dram     = rsp_q.dram;
    assign rsp_pci_fwd  = rsp_q.fwd;
    assign rsp_l1_cache = rsp_q.l1;
    assign rsp_l2_cache = rsp_q.l2;
    assign rsp_claim    = rsp_q.claim;

    // R12: one-clock latency from request to result
    assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R12: no stray flags on idle cycles
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_dram || rsp_pci_fwd || rsp_l1_cache || rsp_l2_cache || rsp_claim));

    // R13: processor cycles pick exactly one destination
    assert_one_dest_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_pci) |-> (rsp_dram != rsp_pci_fwd) && !rsp_claim);

    // R9: bus-master cycles never forward or cache, DRAM follows claim
    assert_master_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_pci) |->
            !rsp_pci_fwd && !rsp_l1_cache && !rsp_l2_cache && (rsp_dram == rsp_claim));

    // R10: hole vetoes bus-master claims
    assert_hole_veto_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_pci && hole_en &&
              (req_addr >= hole_base) && (req_addr < hole_limit)) |-> !rsp_claim);

    // R8: second-level caching only for DRAM-serviced cycles
    assert_l2_needs_dram_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_l2_cache |-> rsp_dram && rsp_l1_cache);

endmodule

// File: tb/test_shadow_attr_router.sv
module test_shadow_attr_router;

    localparam int          ADDR_W = 32;
    localparam int          NREGS  = 4;
    localparam logic [31:0] BASE   = 32'h000C_0000;
    localparam logic [31:0] RSIZE  = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_code = 1'b0;
    logic        req_pci = 1'b0;
    logic        hole_en = 1'b0;
    logic [31:0] hole_base = '0;
    logic [31:0] hole_limit = '0;
    logic        rsp_valid, rsp_dram, rsp_pci_fwd, rsp_l1_cache, rsp_l2_cache, rsp_claim;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shadow_attr_router #(.ADDR_W(ADDR_W), .NUM_REGS(NREGS)) i_shadow_attr_router (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_code(req_code), .req_pci(req_pci),
        .hole_en(hole_en), .hole_base(hole_base), .hole_limit(hole_limit),
        .rsp_valid(rsp_valid), .rsp_dram(rsp_dram), .rsp_pci_fwd(rsp_pci_fwd),
        .rsp_l1_cache(rsp_l1_cache), .rsp_l2_cache(rsp_l2_cache), .rsp_claim(rsp_claim)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // {dram, fwd, l1, l2, claim}
    function automatic logic [4:0] model(input logic [3:0] n, input logic inwin,
                                         input logic w, input logic c, input logic p,
                                         input logic hole);
        logic re, we, ce, serv, l1, l2;
        re = n[0]; we = n[1]; ce = n[2];
        if (p) begin
            serv = (inwin ? (w ? we : re) : 1'b1) && !hole;
            return {serv, 1'b0, 1'b0, 1'b0, serv};
        end
        if (!inwin) return 5'b10110;
        serv = w ? we : re;
        l1 = serv && ce && ((re && we) || (re && !we && c && !w));
        l2 = serv && ce && re && we;
        return {serv, !serv, l1, l2, 1'b0};
    endfunction

    function automatic string tag(input logic [3:0] n, input logic p);
        if (p) return "R9";
        case (n[1:0])
            2'b00:   return "R3";
            2'b01:   return "R4/R7";
            2'b10:   return "R5";
            default: return "R6/R8";
        endcase
    endfunction

    function automatic logic [7:0] outs();
        return {2'b00, rsp_valid, rsp_dram, rsp_pci_fwd, rsp_l1_cache, rsp_l2_cache, rsp_claim};
    endfunction

    task automatic cfg_write(input int idx, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R2 readback", cfg_rdata, v);
    endtask

    task automatic run(input string req, input logic [31:0] a, input logic w,
                       input logic c, input logic p, input logic [4:0] e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_code = c; req_pci = p;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req, outs(), {3'b001, e});
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", outs(), 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < NREGS; i++) begin
            cfg_idx = 2'(i);
            #1;
            chk("R1 reset byte", cfg_rdata, 8'h00);
        end
        run("R1 disabled after reset", BASE + 32'h10, 1'b0, 1'b0, 1'b0, 5'b01000);
        @(negedge clk);
        chk("R12 idle after request", outs(), 8'h00);

        // Sweep every attribute byte over every region and access kind
        for (int v = 0; v < 256; v++) begin
            for (int i = 0; i < NREGS; i++) cfg_write(i, 8'(v));
            for (int r = 0; r < 2 * NREGS; r++) begin
                logic [3:0]  nib;
                logic [31:0] a;
                nib = r[0] ? 4'(v >> 4) : 4'(v);
                a = BASE + RSIZE * 32'(r) + ((32'(v) * 32'd37 + 32'(r) * 32'd301) & 32'h3FFF);
                for (int k = 0; k < 6; k++) begin
                    logic w, c, p;
                    logic [4:0] e;
                    p = (k >= 4);
                    w = p ? k[0] : k[1];
                    c = p ? 1'b0 : k[0];
                    e = model(nib, 1'b1, w, c, p, 1'b0);
                    run(tag(nib, p), a, w, c, p, e);
                    if (!p) chk("R13 one destination", {7'd0, rsp_dram ^ rsp_pci_fwd}, 8'h01);
                end
            end
        end

        // Window edges and outside addresses with all regions disabled
        for (int i = 0; i < NREGS; i++) cfg_write(i, 8'h00);
        run("R11 below window", BASE - 32'h1, 1'b0, 1'b0, 1'b0, 5'b10110);
        run("R11 above window write", BASE + RSIZE * 8, 1'b1, 1'b0, 1'b0, 5'b10110);
        run("R11 low memory", 32'h0000_1000, 1'b0, 1'b1, 1'b0, 5'b10110);
        run("R3 last window byte", BASE + RSIZE * 8 - 1, 1'b1, 1'b0, 1'b0, 5'b01000);
        run("R11 master outside", 32'h0010_0000, 1'b0, 1'b0, 1'b1, 5'b10001);

        // Region-to-nibble mapping with distinct values per region
        cfg_write(1, 8'h21);
        run("R2 even region low nibble", BASE + RSIZE * 2, 1'b0, 1'b0, 1'b0,
            model(4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        run("R2 odd region high nibble", BASE + RSIZE * 3, 1'b0, 1'b0, 1'b0,
            model(4'h2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));

        // Memory hole over region 2 and an outside range
        for (int i = 0; i < NREGS; i++) cfg_write(i, 8'h77);
        hole_en = 1'b1; hole_base = BASE + RSIZE * 2; hole_limit = BASE + RSIZE * 3;
        run("R10 master read in hole", BASE + RSIZE * 2, 1'b0, 1'b0, 1'b1, 5'b00000);
        run("R10 master write in hole", BASE + RSIZE * 3 - 1, 1'b1, 1'b0, 1'b1, 5'b00000);
        run("R10 master at hole limit", BASE + RSIZE * 3, 1'b0, 1'b0, 1'b1, 5'b10001);
        run("R10 cpu ignores hole", BASE + RSIZE * 2, 1'b0, 1'b0, 1'b0, 5'b10110);
        hole_base = 32'h0010_0000; hole_limit = 32'h0020_0000;
        run("R10 hole outside window", 32'h0010_0040, 1'b1, 1'b0, 1'b1, 5'b00000);
        hole_en = 1'b0;
        run("R10 hole disabled", 32'h0010_0040, 1'b1, 1'b0, 1'b1, 5'b10001);
        @(negedge clk);
        chk("R12 idle at end", outs(), 8'h00);

        done = 1'b1;
        finish_up();
    end

endmodule